// File: doc/BRIEF.md
# Host Control Register Image Checker

This block screens the control-register images that a host is about to reload, before any of them take effect. Each check compares a 64-bit CR0, CR3 or CR4 image against the rules for that register. CR0 and CR4 are each checked against a pair of masks. One mask lists the bits that must read 1. The other lists the bits that must read 0. CR3 is checked against a physical-address width: a high band of CR3 must always be zero, and a middle band must be zero above that width.

A caller presents all images, masks and the width together with a one-cycle `start` pulse. One cycle later the block raises `done` for a single cycle. At the same time it presents one failure flag per register and an overall pass bit. These results stay fixed until the next `start`.

Top module: `hcr_guard`

## Requirements
- R1: After reset, `done`, `pass`, `cr0_bad`, `cr3_bad` and `cr4_bad` are all 0.
- R2: A `start` sampled high at a rising edge makes `done` read 1 after that edge. `done` reads 0 after any edge at which `start` was low.
- R3: The four result outputs change only at an edge where `start` is high. They hold their values at all other edges, whatever the other inputs do.
- R4: `cr0_bad` is set when some CR0 bit is 0 while the same bit of `cr0_set_req` is 1. It is also set when some CR0 bit is 1 while the same bit of `cr0_clr_req` is 1. Bit i of each mask governs bit i of the image.
- R5: CR0 bits 29 and 30 are exempt from R4. Their values and their mask bits never set `cr0_bad`.
- R6: `cr4_bad` follows the R4 rule using `cr4_set_req` and `cr4_clr_req`, over all 64 bits and with no exemptions.
- R7: Any 1 in CR3 bits 63:52 sets `cr3_bad`.
- R8: A 1 in CR3 bit i, for 32 <= i <= 51, sets `cr3_bad` exactly when i >= `pa_width`. With a width of 32 or less, every bit in 51:32 must be 0. With a width of 52 or more, none of them is checked. CR3 bits 31:0 are never checked.
- R9: `pass` is 1 exactly when none of the three flags is set in the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sample all inputs and evaluate |
| cr0_val | input | 64 | CR0 image |
| cr3_val | input | 64 | CR3 image |
| cr4_val | input | 64 | CR4 image |
| cr0_set_req | input | 64 | CR0 bits required to be 1 |
| cr0_clr_req | input | 64 | CR0 bits required to be 0 |
| cr4_set_req | input | 64 | CR4 bits required to be 1 |
| cr4_clr_req | input | 64 | CR4 bits required to be 0 |
| pa_width | input | 8 | Physical-address width in bits |
| done | output | 1 | One-cycle result strobe |
| cr0_bad | output | 1 | CR0 image violates its masks |
| cr3_bad | output | 1 | CR3 image sets a forbidden high bit |
| cr4_bad | output | 1 | CR4 image violates its masks |
| pass | output | 1 | No register failed |

## Verification
The assertions read the images, masks and width only at an edge where `start` is high. They assume nothing about these inputs at other times, so the bench changes the images to unrelated values between runs to exercise the hold behaviour. The assertions also do not require the two masks of a register to be disjoint. The bench keeps each mask pair consistent in its compliant cases, so that a pass really means the image meets its rules. The stimulus sweeps a single offending bit across all 64 positions for each mask and for CR3, and it sweeps the address width from 0 to 63.

// File: rtl/hcr_guard.sv
module hcr_guard #(
  parameter int XLEN       = 64,
  parameter int PAW        = 8,
  parameter int CR3_TOP_LO = 52,
  parameter int CR3_VAR_LO = 32,
  parameter int CR0_SKIP_A = 29,
  parameter int CR0_SKIP_B = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] cr0_val,
  input  logic [XLEN-1:0] cr3_val,
  input  logic [XLEN-1:0] cr4_val,
  input  logic [XLEN-1:0] cr0_set_req,
  input  logic [XLEN-1:0] cr0_clr_req,
  input  logic [XLEN-1:0] cr4_set_req,
  input  logic [XLEN-1:0] cr4_clr_req,
  input  logic [PAW-1:0]  pa_width,
  output logic            done,
  output logic            cr0_bad,
  output logic            cr3_bad,
  output logic            cr4_bad,
  output logic            pass
);

  localparam logic [XLEN-1:0] CR0_SKIP = (XLEN'(1) << CR0_SKIP_A) | (XLEN'(1) << CR0_SKIP_B);

  logic [XLEN-1:0] cr3_zero_mask;
  logic            cr0_fail, cr3_fail, cr4_fail;

  for (genvar i = 0; i < XLEN; i++) begin : g_cr3_mask
    if (i >= CR3_TOP_LO) begin : g_fixed
      assign cr3_zero_mask[i] = 1'b1;
    end else if (i >= CR3_VAR_LO) begin : g_var
      assign cr3_zero_mask[i] = (i >= int'(pa_width));
    end else begin : g_free
      assign cr3_zero_mask[i] = 1'b0;
    end
  end

  assign cr0_fail = |(((cr0_set_req & ~cr0_val) | (cr0_clr_req & cr0_val)) & ~CR0_SKIP);
  assign cr4_fail = |((cr4_set_req & ~cr4_val) | (cr4_clr_req & cr4_val));
  assign cr3_fail = |(cr3_val & cr3_zero_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      cr0_bad <= 1'b0;
      cr3_bad <= 1'b0;
      cr4_bad <= 1'b0;
      pass    <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        cr0_bad <= cr0_fail;
        cr3_bad <= cr3_fail;
        cr4_bad <= cr4_fail;
        pass    <= ~(cr0_fail | cr3_fail | cr4_fail);
      end
    end
  end

endmodule

// File: rtl/hcr_guard_chk.sv
module hcr_guard_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [XLEN-1:0] cr3_val,
  input logic [XLEN-1:0] cr4_val,
  input logic [XLEN-1:0] cr4_set_req,
  input logic [XLEN-1:0] cr4_clr_req,
  input logic            done,
  input logic            cr0_bad,
  input logic            cr3_bad,
  input logic            cr4_bad,
  input logic            pass
);

  // R2
  done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> done);

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done);

  // R3
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(cr0_bad) && $stable(cr3_bad) && $stable(cr4_bad) && $stable(pass)));

  // R7
  cr3_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (cr3_val[XLEN-1:52] != '0)) |=> cr3_bad);

  // R6
  cr4_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ((cr4_set_req & ~cr4_val) != '0 || (cr4_clr_req & cr4_val) != '0)) |=> cr4_bad);

  // R9
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> !(cr0_bad || cr3_bad || cr4_bad));

  // R9
  pass_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cr0_bad && !cr3_bad && !cr4_bad) |-> pass);

endmodule

bind hcr_guard hcr_guard_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cr3_val(cr3_val), .cr4_val(cr4_val),
  .cr4_set_req(cr4_set_req), .cr4_clr_req(cr4_clr_req), .done(done),
  .cr0_bad(cr0_bad), .cr3_bad(cr3_bad), .cr4_bad(cr4_bad), .pass(pass)
);

// File: tb/hcr_guard_tb.sv
module hcr_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [63:0] cr0_val = '0, cr3_val = '0, cr4_val = '0;
  logic [63:0] cr0_set_req = '0, cr0_clr_req = '0, cr4_set_req = '0, cr4_clr_req = '0;
  logic [7:0]  pa_width = 8'd52;
  logic done, cr0_bad, cr3_bad, cr4_bad, pass;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hcr_guard dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cr0_val(cr0_val), .cr3_val(cr3_val), .cr4_val(cr4_val),
    .cr0_set_req(cr0_set_req), .cr0_clr_req(cr0_clr_req),
    .cr4_set_req(cr4_set_req), .cr4_clr_req(cr4_clr_req),
    .pa_width(pa_width), .done(done), .cr0_bad(cr0_bad), .cr3_bad(cr3_bad),
    .cr4_bad(cr4_bad), .pass(pass)
  );

  task automatic check(string req, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b (cr0,cr3,cr4,pass)", req, got, exp);
    end
  endtask

  task automatic run(string req, logic e0, logic e3, logic e4);
    logic [3:0] exp;
    exp = {e0, e3, e4, ~(e0 | e3 | e4)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2", {3'b000, done}, 4'b0001);
    check(req, {cr0_bad, cr3_bad, cr4_bad, pass}, exp);
    cr0_val = ~cr0_val; cr3_val = ~cr3_val; cr4_val = ~cr4_val;
    @(negedge clk);
    check("R2", {3'b000, done}, 4'b0000);
    check("R3", {cr0_bad, cr3_bad, cr4_bad, pass}, exp);
    cr0_val = '0; cr3_val = '0; cr4_val = '0;
    cr0_set_req = '0; cr0_clr_req = '0; cr4_set_req = '0; cr4_clr_req = '0;
    pa_width = 8'd52;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {cr0_bad, cr3_bad, cr4_bad, pass}, 4'b0000);
    check("R1", {3'b000, done}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {cr0_bad, cr3_bad, cr4_bad, pass}, 4'b0000);

    run("R9", 1'b0, 1'b0, 1'b0);

    for (int b = 0; b < 64; b++) begin
      logic ex;
      ex = (b != 29) && (b != 30);
      cr0_set_req = 64'd1 << b;
      run(ex ? "R4" : "R5", ex, 1'b0, 1'b0);
      cr0_clr_req = 64'd1 << b; cr0_val = 64'd1 << b;
      run(ex ? "R4" : "R5", ex, 1'b0, 1'b0);
      cr0_set_req = 64'd1 << b; cr0_clr_req = 64'd1 << ((b + 1) % 64); cr0_val = 64'd1 << b;
      run("R4", 1'b0, 1'b0, 1'b0);
      cr4_set_req = 64'd1 << b;
      run("R6", 1'b0, 1'b0, 1'b1);
      cr4_clr_req = 64'd1 << b; cr4_val = 64'd1 << b;
      run("R6", 1'b0, 1'b0, 1'b1);
      cr4_set_req = 64'd1 << b; cr4_clr_req = 64'd1 << ((b + 1) % 64); cr4_val = 64'd1 << b;
      run("R6", 1'b0, 1'b0, 1'b0);
    end

    for (int w = 0; w < 64; w++) begin
      for (int b = 0; b < 64; b++) begin
        logic e3;
        e3 = (b >= 52) || (b >= 32 && b >= w);
        cr3_val = 64'd1 << b;
        pa_width = 8'(w);
        run(b >= 52 ? "R7" : "R8", 1'b0, e3, 1'b0);
      end
    end

    cr0_set_req = 64'd1; cr3_val = 64'd1 << 40; pa_width = 8'd36;
    cr4_clr_req = 64'd4; cr4_val = 64'd4;
    run("R9", 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule